// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block times the serial clock and data edges of one bit on an I2C bus for a master. A kernel clock is divided by a programmable prescaler into a timebase. Every other delay is a count of timebase periods: the SCL low time, the SCL high time, the data hold delay and the data setup delay. The two line outputs are open-drain enables, where 1 pulls the wire low. The surrounding controller sequences START and STOP, handles whole bytes and filters the line inputs. That controller asks for one bit at a time and uses two one-cycle strobes. The first marks where SDA is updated. The second marks the end of the bit, at the SCL falling edge.

A bit request is accepted only in the idle state. Accepting it drives SCL low, or keeps it low, and starts the low phase. SDA is updated after the hold delay. SCL is released once two conditions are met: the setup delay has elapsed since the SDA update, and the full low period has elapsed since acceptance. The high phase counts only the cycles in which the sampled SCL level is high, so a slave that stretches the clock lengthens the high phase. At the end of the high phase SCL is pulled low again and stays low until the next request.

The timing word is taken only while the block is disabled. Clearing the enable releases both lines and abandons any bit in progress.

Top module: `i2c_bit_timer`

## Requirements
- R1: During reset and while `en` is low, `scl_oe`, `sda_oe`, `sda_upd` and `bit_done` are all 0. Clearing `en` during a bit releases both lines on the following clock edge.
- R2: The timebase period is (PRE+1) kernel cycles, where PRE is `cfg_word[3:0]`. Every delay below is an exact multiple of this period.
- R3: On the clock edge that accepts a request, `scl_oe` becomes 1. After HOLD timebase periods, with no +1, `sda_oe` becomes the inverse of the requested bit and `sda_upd` pulses for one cycle. HOLD is `cfg_word[23:20]`. When HOLD is 0, the update happens on the accepting edge itself.
- R4: `scl_oe` returns to 0 max(LO+1, HOLD+SETUP+1) timebase periods after the accepting edge. LO is `cfg_word[11:4]` and SETUP is `cfg_word[27:24]`. This gives at least SETUP+1 periods between the SDA update and the SCL release.
- R5: `sda_oe` changes only while `scl_oe` is 1, apart from the release caused by clearing `en`.
- R6: After release, `scl_oe` returns to 1 and `bit_done` pulses once (HI+1)·(PRE+1) cycles have elapsed in which `scl_in` was sampled high. HI is `cfg_word[19:12]`. Each cycle in which `scl_in` is sampled low adds one cycle to this phase.
- R7: `cfg_word` is captured only while `en` is low. A change made while `en` is high has no effect on the timing.
- R8: `bit_req` is ignored while `en` is low and while a bit is in progress. An ignored request produces no strobe and leaves both lines unchanged.
- R9: After `en` rises, SCL and SDA stay released until the first accepted request. Between bits, SCL is held low and SDA keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Block enable; low releases the lines and opens the timing capture |
| cfg_word | input | 28 | Timing word: PRE[3:0], LO[11:4], HI[19:12], HOLD[23:20], SETUP[27:24] |
| bit_req | input | 1 | Request to send the next bit |
| bit_val | input | 1 | Bit value sampled with the accepted request |
| scl_in | input | 1 | Sampled SCL wire level |
| scl_oe | output | 1 | SCL pull-low enable |
| sda_oe | output | 1 | SDA pull-low enable |
| sda_upd | output | 1 | One-cycle strobe at the SDA update point |
| bit_done | output | 1 | One-cycle strobe at the end of the bit (SCL falls) |

## Verification
Three timing words are used. In the first, the LO count is longer than hold plus setup. In the second, hold plus setup is longer than LO and the prescaler is not 1, which shows which bound sets the release point and that every delay scales with PRE+1. The third has a zero hold delay, which separates the no-offset hold count from the +1 counts. Bits of both values are sent back to back, and one bit has a stretched high phase to show that low-sampled cycles add to the high time. Further runs apply a timing change while enabled, requests while disabled or mid-bit, and a disable in the middle of a bit, and observe the lines and strobes directly afterwards.

// File: rtl/i2c_bt_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C bit timing generator.
// Assumes nothing beyond elaboration-time constant evaluation.
package i2c_bt_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_IDLE  = 3'd1,
        ST_HOLD  = 3'd2,
        ST_SETUP = 3'd3,
        ST_HIGH  = 3'd4
    } bt_state_e;

    // Larger of two widths, used to size counters.
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/i2c_bt_cfg.sv
`timescale 1ns/1ps
// Timing word capture. The word is copied on every clock while the block
// is disabled and frozen while enabled. Field layout from bit 0 upward:
// prescaler, low count, high count, hold delay, setup delay.
module i2c_bt_cfg #(
    parameter int PRE_W = 4,
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int DEL_W = 4,
    localparam int CFG_W = PRE_W + LO_W + HI_W + 2 * DEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CFG_W-1:0] cfg_word,
    output logic [PRE_W-1:0] pre,
    output logic [LO_W-1:0]  lo,
    output logic [HI_W-1:0]  hi,
    output logic [DEL_W-1:0] hold,
    output logic [DEL_W-1:0] setup
);
    localparam int LO_LSB    = PRE_W;
    localparam int HI_LSB    = LO_LSB + LO_W;
    localparam int HOLD_LSB  = HI_LSB + HI_W;
    localparam int SETUP_LSB = HOLD_LSB + DEL_W;

    logic [CFG_W-1:0] cfg_q;

    // Track the input word only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_q <= '0;
        else if (!en)
            cfg_q <= cfg_word;
    end

    assign pre   = cfg_q[LO_LSB-1:0];
    assign lo    = cfg_q[HI_LSB-1:LO_LSB];
    assign hi    = cfg_q[HOLD_LSB-1:HI_LSB];
    assign hold  = cfg_q[SETUP_LSB-1:HOLD_LSB];
    assign setup = cfg_q[CFG_W-1:SETUP_LSB];
endmodule

// File: rtl/i2c_bt_tick.sv
`timescale 1ns/1ps
// Timebase prescaler. Emits one tick per (pre+1) enabled cycles.
// clr forces phase zero. run gates the count, so a stalled cycle does
// not advance the timebase.
module i2c_bt_tick #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    logic [PRE_W-1:0] pc;

    assign tick = run && (pc == pre);

    // Divide the kernel clock, wrapping at the programmed prescaler value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (clr)
            pc <= '0;
        else if (run)
            pc <= (pc == pre) ? '0 : pc + 1'b1;
    end
endmodule

// File: rtl/i2c_bt_seq.sv
`timescale 1ns/1ps
// Bit phase sequencer. It walks the phases hold, setup and high for one
// accepted request and drives the two open-drain enables and the two
// strobes. It assumes the tick comes from a prescaler that it clears
// while idle and stalls while SCL is sampled low in the high phase.
module i2c_bt_seq
    import i2c_bt_pkg::*;
#(
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int DEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             scl_in,
    input  logic [LO_W-1:0]  lo,
    input  logic [HI_W-1:0]  hi,
    input  logic [DEL_W-1:0] hold,
    input  logic [DEL_W-1:0] setup,
    output logic             tb_clr,
    output logic             tb_run,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             sda_upd,
    output logic             bit_done
);
    localparam int CNT_W = max2(HI_W, DEL_W) + 1;
    localparam int LC_W  = max2(LO_W, DEL_W + 1) + 1;

    bt_state_e        st;
    logic [CNT_W-1:0] ph;
    logic [LC_W-1:0]  lc;
    logic             bit_q;

    logic [CNT_W-1:0] hold_w, setup_w, hi_w;
    logic [LC_W-1:0]  lo_w;
    logic             hold_end, setup_end, high_end;

    assign hold_w  = CNT_W'(hold);
    assign setup_w = CNT_W'(setup);
    assign hi_w    = CNT_W'(hi);
    assign lo_w    = LC_W'(lo);

    // Phase completion on the current tick.
    assign hold_end  = (ph == hold_w - CNT_W'(1));
    assign setup_end = (ph >= setup_w) && (lc >= lo_w);
    assign high_end  = (ph == hi_w);

    // Timebase control: idle phases restart it; the high phase waits on SCL.
    always_comb begin
        tb_clr = (st == ST_OFF) || (st == ST_IDLE);
        tb_run = (st == ST_HOLD) || (st == ST_SETUP) ||
                 ((st == ST_HIGH) && scl_in);
    end

    // Phase state, counters, line enables and strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_OFF;
            ph       <= '0;
            lc       <= '0;
            bit_q    <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
            sda_upd  <= 1'b0;
            bit_done <= 1'b0;
        end else begin
            sda_upd  <= 1'b0;
            bit_done <= 1'b0;
            if (!en) begin
                st     <= ST_OFF;
                scl_oe <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_OFF: st <= ST_IDLE;
                    ST_IDLE: begin
                        if (bit_req) begin
                            scl_oe <= 1'b1;
                            bit_q  <= bit_val;
                            ph     <= '0;
                            lc     <= '0;
                            if (hold_w == '0) begin
                                sda_oe  <= !bit_val;
                                sda_upd <= 1'b1;
                                st      <= ST_SETUP;
                            end else begin
                                st <= ST_HOLD;
                            end
                        end
                    end
                    ST_HOLD: begin
                        if (tick) begin
                            lc <= lc + 1'b1;
                            if (hold_end) begin
                                sda_oe  <= !bit_q;
                                sda_upd <= 1'b1;
                                ph      <= '0;
                                st      <= ST_SETUP;
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    ST_SETUP: begin
                        if (tick) begin
                            lc <= lc + 1'b1;
                            if (setup_end) begin
                                scl_oe <= 1'b0;
                                ph     <= '0;
                                st     <= ST_HIGH;
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    ST_HIGH: begin
                        if (tick) begin
                            if (high_end) begin
                                scl_oe   <= 1'b1;
                                bit_done <= 1'b1;
                                st       <= ST_IDLE;
                            end else begin
                                ph <= ph + 1'b1;
                            end
                        end
                    end
                    default: st <= ST_OFF;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_bit_timer.sv
`timescale 1ns/1ps
// I2C master bit timing generator top. It connects the timing capture,
// the prescaler and the phase sequencer. It assumes scl_in is already
// synchronised to clk and that START/STOP framing is done outside.
module i2c_bit_timer #(
    parameter int PRE_W = 4,
    parameter int LO_W  = 8,
    parameter int HI_W  = 8,
    parameter int DEL_W = 4,
    localparam int CFG_W = PRE_W + LO_W + HI_W + 2 * DEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             bit_req,
    input  logic             bit_val,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             sda_upd,
    output logic             bit_done
);
    logic [PRE_W-1:0] pre;
    logic [LO_W-1:0]  lo;
    logic [HI_W-1:0]  hi;
    logic [DEL_W-1:0] hold, setup;
    logic             tick, tb_clr, tb_run;

    i2c_bt_cfg #(.PRE_W(PRE_W), .LO_W(LO_W), .HI_W(HI_W), .DEL_W(DEL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word),
        .pre(pre), .lo(lo), .hi(hi), .hold(hold), .setup(setup)
    );

    i2c_bt_tick #(.PRE_W(PRE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(tb_clr), .run(tb_run),
        .pre(pre), .tick(tick)
    );

    i2c_bt_seq #(.LO_W(LO_W), .HI_W(HI_W), .DEL_W(DEL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .bit_req(bit_req), .bit_val(bit_val), .scl_in(scl_in),
        .lo(lo), .hi(hi), .hold(hold), .setup(setup),
        .tb_clr(tb_clr), .tb_run(tb_run),
        .scl_oe(scl_oe), .sda_oe(sda_oe),
        .sda_upd(sda_upd), .bit_done(bit_done)
    );
endmodule

// File: rtl/i2c_bt_chk.sv
`timescale 1ns/1ps
// Port-level protocol checker for the bit timing generator, bound to
// every instance of the top module.
module i2c_bt_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bit_req,
    input logic scl_in,
    input logic scl_oe,
    input logic sda_oe,
    input logic sda_upd,
    input logic bit_done
);
    // R1
    lines_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe && !sda_upd && !bit_done));

    // R5
    sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (sda_upd || !$past(en)));

    // R5
    sda_under_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_upd |-> scl_oe);

    // R6
    done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_done |-> scl_oe);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !scl_oe && !scl_in && !bit_req) |=> !scl_oe);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sda_upd, bit_done}));
endmodule

bind i2c_bit_timer i2c_bt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .bit_req(bit_req), .scl_in(scl_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_upd(sda_upd), .bit_done(bit_done)
);

// File: tb/i2c_bit_timer_test.sv
`timescale 1ns/1ps
module i2c_bit_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [27:0] cfg_word = '0;
    logic        bit_req = 1'b0;
    logic        bit_val = 1'b0;
    logic        scl_in;
    logic        scl_oe, sda_oe, sda_upd, bit_done;
    logic        stretch_act = 1'b0;

    int cyc = 0;
    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    int m_pre, m_lo, m_hi, m_hold, m_setup;
    int stretch_n = 0;
    bit stretch_go = 1'b0;

    typedef struct packed {
        logic [1:0]  kind;
        logic [31:0] at;
        logic        lvl;
    } exp_t;
    exp_t  q[$];
    string tq[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_in = !scl_oe && !stretch_act;

    i2c_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word),
        .bit_req(bit_req), .bit_val(bit_val), .scl_in(scl_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_upd(sda_upd), .bit_done(bit_done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Slave model: hold SCL low for stretch_n cycles after each release.
    bit go_seen = 1'b0;
    int left = 0;
    always @(negedge clk) begin
        if (stretch_go != go_seen) begin
            go_seen = stretch_go;
            left = stretch_n;
        end
        if (!scl_oe && left > 0) begin
            stretch_act <= 1'b1;
            left = left - 1;
        end else begin
            stretch_act <= 1'b0;
        end
    end

    task automatic take(input int kind, input logic lvl);
        exp_t  e;
        string tg;
        if (q.size() == 0) begin
            check(1'b0, "R8", "unexpected event kind", kind, -1);
        end else begin
            e  = q.pop_front();
            tg = tq.pop_front();
            check(int'(e.kind) == kind, tg, "event kind", kind, int'(e.kind));
            check(cyc == int'(e.at), tg, "event cycle", cyc, int'(e.at));
            check(lvl == e.lvl, tg, "line level", int'(lvl), int'(e.lvl));
        end
    endtask

    // Monitor: pop the expected item for each observed event and compare.
    logic prev_scl = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (sda_upd) take(0, sda_oe);
            if (prev_scl && !scl_oe && en) take(1, scl_oe);
            if (bit_done) take(2, scl_oe);
        end
        prev_scl = scl_oe;
    end

    function automatic logic [27:0] pack(input int pre, input int lo, input int hi,
                                         input int hold, input int setup);
        return {4'(setup), 4'(hold), 8'(hi), 8'(lo), 4'(pre)};
    endfunction

    task automatic set_cfg(input int pre, input int lo, input int hi,
                           input int hold, input int setup);
        cfg_word = pack(pre, lo, hi, hold, setup);
        m_pre = pre; m_lo = lo; m_hi = hi; m_hold = hold; m_setup = setup;
    endtask

    task automatic push(input int kind, input int at, input logic lvl, input string tg);
        exp_t e;
        e.kind = 2'(kind);
        e.at   = 32'(at);
        e.lvl  = lvl;
        q.push_back(e);
        tq.push_back(tg);
    endtask

    // Driver: queue the expected events of one bit, then issue the request.
    task automatic send_bit(input logic v, input int s, input string tg);
        int t, dl, base;
        t    = m_pre + 1;
        dl   = (m_lo + 1 > m_hold + m_setup + 1) ? m_lo + 1 : m_hold + m_setup + 1;
        base = cyc + 1;
        push(0, base + m_hold * t, !v, tg);
        push(1, base + dl * t, 1'b0, tg);
        push(2, base + (dl + m_hi + 1) * t + s, 1'b1, tg);
        bit_val = v;
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        stretch_n = s;
        stretch_go = !stretch_go;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!bit_done);
    endtask

    task automatic hold_check(input int n, input logic e_scl, input logic e_sda,
                              input string tg);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (scl_oe !== e_scl || sda_oe !== e_sda) bad++;
        end
        check(bad == 0, tg, "cycles with lines moved", bad, 0);
    endtask

    initial begin
        set_cfg(0, 3, 2, 1, 0);
        repeat (3) @(negedge clk);
        // R1: reset state
        check({scl_oe, sda_oe, sda_upd, bit_done} == 4'b0, "R1", "outputs in reset",
              int'({scl_oe, sda_oe, sda_upd, bit_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b1;
        // R9: released after enable until a request
        hold_check(5, 1'b0, 1'b0, "R9");

        // R3/R4/R6: LO-dominated low phase, prescaler 1
        send_bit(1'b0, 0, "R3");
        wait_done();
        send_bit(1'b1, 0, "R4");
        wait_done();
        send_bit(1'b0, 3, "R6");
        wait_done();

        // R8: request in the high phase is ignored; R9 lines hold between bits
        send_bit(1'b1, 0, "R8");
        while (scl_oe) @(negedge clk);
        bit_val = 1'b0;
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        wait_done();
        hold_check(15, 1'b1, 1'b0, "R9");

        // R7: change while enabled has no effect
        cfg_word = pack(2, 1, 1, 3, 2);
        send_bit(1'b0, 0, "R7");
        wait_done();

        // R7: capture while disabled; R2 prescaler 3, setup-dominated low phase
        en = 1'b0;
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R1", "lines after disable", int'({scl_oe, sda_oe}), 0);
        set_cfg(2, 1, 1, 3, 2);
        @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        send_bit(1'b0, 0, "R7");
        wait_done();
        send_bit(1'b1, 2, "R2");
        wait_done();

        // R3: zero hold delay
        en = 1'b0;
        set_cfg(1, 2, 0, 0, 1);
        repeat (2) @(negedge clk);
        en = 1'b1;
        repeat (2) @(negedge clk);
        send_bit(1'b0, 0, "R3");
        wait_done();
        send_bit(1'b1, 0, "R3");
        wait_done();

        // R8: request while disabled is ignored
        en = 1'b0;
        @(negedge clk);
        bit_val = 1'b0;
        bit_req = 1'b1;
        @(negedge clk);
        bit_req = 1'b0;
        hold_check(8, 1'b0, 1'b0, "R8");

        // R1: disable mid-bit aborts and releases
        en = 1'b1;
        repeat (2) @(negedge clk);
        send_bit(1'b0, 0, "R1");
        while (!sda_upd) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(!scl_oe && !sda_oe, "R1", "lines after abort", int'({scl_oe, sda_oe}), 0);
        q.delete();
        tq.delete();
        hold_check(6, 1'b0, 1'b0, "R1");

        check(q.size() == 0, "R6", "pending events", q.size(), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL R6: watchdog expired actual %0d expected %0d", cyc, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule